// File: doc/BRIEF.md
# Profile-Selected Quadrature Modulator Core

This core places baseband in-phase and quadrature samples onto a digitally generated carrier. A 32-bit phase accumulator advances by a tuning word every clock. The top ten bits of its phase address a sine/cosine table that stores one quarter of a wave. The products of the samples with the carrier are combined, rounded and saturated into one 12-bit two's-complement sample per clock. The samples arrive already interpolated to the system clock rate.

Four register sets ("profiles") each hold a tuning word, a mode bit and a sideband-sign bit. Two select pins choose the active set. The mode bit picks quadrature modulation or a bare carrier (tone). The sign bit picks whether the quadrature product is subtracted (the default) or added. Software loads a profile through a single-cycle parallel write port. Switching profiles never resets the accumulator, so the carrier phase stays continuous across a switch.

Top module: `qmod_core`

## Requirements
- R1: While rst_ni is low and after its release, out_o is 0, the phase is 0, and every profile holds tuning word 0, quadrature mode and subtract sign.
- R2: On each rising clock edge the phase advances by the tuning word of the profile that psel_i selects at that edge, modulo 2^32. The carrier sample used is cos/sin of 2π(p+0.5)/1024 scaled by 2047 and rounded, where p is the top 10 phase bits.
- R3: In quadrature mode with sign bit 0, out_o = sat(floor((I·cos − Q·sin + 1024) / 2048)), with I and Q taken as 12-bit two's complement.
- R4: In quadrature mode with sign bit 1, out_o = sat(floor((I·cos + Q·sin + 1024) / 2048)).
- R5: In tone mode, out_o equals the cosine sample and i_i and q_i have no effect.
- R6: psel_i picks profile 0..3, and a new selection first applies at the next edge with no phase discontinuity.
- R7: Results above 2047 give 2047 and results below −2048 give −2048.
- R8: Inputs and the carrier sample captured at one edge appear on out_o after the third edge, counting that one.
- R9: With we_i high at an edge, profile waddr_i loads wdata_i. Bits 33:2 are the tuning word, bit 1 is the mode (1 = tone) and bit 0 is the sign (1 = add). The new values apply from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Profile write enable |
| waddr_i | input | 2 | Profile index to write |
| wdata_i | input | 34 | Profile contents {tuning word, tone, add} |
| psel_i | input | 2 | Active profile select |
| i_i | input | 12 | In-phase sample, two's complement |
| q_i | input | 12 | Quadrature sample, two's complement |
| out_o | output | 12 | Modulated sample, two's complement |

## Verification
The bench switches profiles every few cycles while the tuning words differ. A design that reset the accumulator on a switch, or that applied a new profile one edge early or late, would lose phase and miss the model at once. All four profiles are driven with both sign settings and in tone mode. A reversed sign bit flips the quadrature term, and a tone path that leaks I or Q shows large errors under random samples. Directed runs at full-scale opposite-sign inputs reach both rails, which catches wrap-around instead of saturation. A tuning word of all ones makes the phase wrap backwards, which exercises every quadrant mirror of the table.

// File: rtl/qmod_pkg.sv
package qmod_pkg;
  parameter int DW      = 12;
  parameter int PW      = 32;
  parameter int LUT_AW  = 10;
  parameter int NPROF   = 4;

  typedef struct packed {
    logic [PW-1:0] ftw;
    logic          tone;
    logic          inv;
  } prof_t;

  // quarter-wave sine at (k+0.5)*(pi/2)/n, scaled by amp, Taylor to x^11 in Q30
  function automatic int qsin(input int k, input int n, input int amp);
    longint s, pi_s, x, x2, t;
    s    = 64'sd1 <<< 30;
    pi_s = 64'sd3373259426;
    x    = (longint'(2 * k + 1) * pi_s) / longint'(4 * n);
    x2   = (x * x) >>> 30;
    t    = s;
    t    = s - ((x2 * t) >>> 30) / 110;
    t    = s - ((x2 * t) >>> 30) / 72;
    t    = s - ((x2 * t) >>> 30) / 42;
    t    = s - ((x2 * t) >>> 30) / 20;
    t    = s - ((x2 * t) >>> 30) / 6;
    t    = (x * t) >>> 30;
    return int'((t * longint'(amp) + (s >>> 1)) >>> 30);
  endfunction
endpackage

// File: rtl/qmod_prof_regs.sv
module qmod_prof_regs
  import qmod_pkg::*;
#(
  parameter int NP = NPROF,
  localparam int AW = $clog2(NP)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  prof_t         wdata_i,
  input  logic [AW-1:0] psel_i,
  output prof_t         prof_o
);
  prof_t prof_q [NP];

  for (genvar p = 0; p < NP; p++) begin : g_prof
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            prof_q[p] <= '0;
      else if (we_i && waddr_i == AW'(p))     prof_q[p] <= wdata_i;
    end
  end

  assign prof_o = prof_q[psel_i];

  // R9
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> prof_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/qmod_nco.sv
module qmod_nco
  import qmod_pkg::*;
#(
  parameter int P_W  = PW,
  parameter int A_W  = LUT_AW,
  parameter int D_W  = DW,
  localparam int QB  = A_W - 2,
  localparam int QN  = 1 << QB,
  localparam int AMP = (1 << (D_W - 1)) - 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [P_W-1:0]        ftw_i,
  output logic signed [D_W-1:0] cos_o,
  output logic signed [D_W-1:0] sin_o
);
  logic [P_W-1:0] phase_q;
  logic [D_W-2:0] lut [QN];

  for (genvar k = 0; k < QN; k++) begin : g_lut
    assign lut[k] = (D_W-1)'(qsin(k, QN, AMP));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_q + ftw_i;
  end

  logic [1:0]            quad;
  logic [QB-1:0]         idx;
  logic signed [D_W-1:0] a_p, b_p;

  assign quad = phase_q[P_W-1 -: 2];
  assign idx  = phase_q[P_W-3 -: QB];
  assign a_p  = $signed({1'b0, lut[idx]});
  assign b_p  = $signed({1'b0, lut[~idx]});

  always_comb begin
    unique case (quad)
      2'd0: begin sin_o =  a_p; cos_o =  b_p; end
      2'd1: begin sin_o =  b_p; cos_o = -a_p; end
      2'd2: begin sin_o = -a_p; cos_o = -b_p; end
      default: begin sin_o = -b_p; cos_o = a_p; end
    endcase
  end

  // R2
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == $past(phase_q) + $past(ftw_i));
endmodule

// File: rtl/qmod_mix.sv
module qmod_mix
  import qmod_pkg::*;
#(
  parameter int D_W = DW,
  localparam int SW = 2 * D_W + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic signed [D_W-1:0] i_i,
  input  logic signed [D_W-1:0] q_i,
  input  logic signed [D_W-1:0] cos_i,
  input  logic signed [D_W-1:0] sin_i,
  input  logic                  tone_i,
  input  logic                  inv_i,
  output logic signed [D_W-1:0] out_o
);
  localparam logic signed [SW-1:0] RND  = SW'(1) <<< (D_W - 2);
  localparam logic signed [SW-1:0] MAXV = (SW'(1) <<< (D_W - 1)) - SW'(1);
  localparam logic signed [SW-1:0] MINV = -(SW'(1) <<< (D_W - 1));

  logic signed [D_W-1:0] i_r, q_r, c_r, s_r;
  logic                  tone_r, inv_r;
  logic signed [2*D_W-1:0] pi, pq;
  logic signed [SW-1:0]  sum_d, sum_r, rnd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_r <= '0; q_r <= '0; c_r <= '0; s_r <= '0; tone_r <= 1'b0; inv_r <= 1'b0;
    end else begin
      i_r <= i_i; q_r <= q_i; c_r <= cos_i; s_r <= sin_i; tone_r <= tone_i; inv_r <= inv_i;
    end
  end

  assign pi = i_r * c_r;
  assign pq = q_r * s_r;

  always_comb begin
    if (tone_r)     sum_d = SW'(c_r) <<< (D_W - 1);
    else if (inv_r) sum_d = SW'(pi) + SW'(pq);
    else            sum_d = SW'(pi) - SW'(pq);
  end

  assign rnd = (sum_r + RND) >>> (D_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_r <= '0;
      out_o <= '0;
    end else begin
      sum_r <= sum_d;
      if (rnd > MAXV)      out_o <= D_W'(MAXV);
      else if (rnd < MINV) out_o <= D_W'(MINV);
      else                 out_o <= rnd[D_W-1:0];
    end
  end

  // R5
  tone_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tone_r |=> ##1 (out_o == $past(c_r, 2)));
  // R7
  sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rnd > MAXV) |=> out_o == D_W'(MAXV));
  // R7
  sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rnd < MINV) |=> out_o == D_W'(MINV));
endmodule

// File: rtl/qmod_core.sv
module qmod_core
  import qmod_pkg::*;
#(
  parameter int D_W = DW,
  parameter int P_W = PW,
  parameter int A_W = LUT_AW,
  parameter int NP  = NPROF,
  localparam int SA = $clog2(NP),
  localparam int WW = P_W + 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [SA-1:0]         waddr_i,
  input  logic [WW-1:0]         wdata_i,
  input  logic [SA-1:0]         psel_i,
  input  logic signed [D_W-1:0] i_i,
  input  logic signed [D_W-1:0] q_i,
  output logic signed [D_W-1:0] out_o
);
  prof_t                 act;
  logic signed [D_W-1:0] cos_w, sin_w;

  qmod_prof_regs #(.NP(NP)) u_regs (
    .clk_i, .rst_ni, .we_i, .waddr_i,
    .wdata_i(prof_t'(wdata_i)), .psel_i, .prof_o(act)
  );

  qmod_nco #(.P_W(P_W), .A_W(A_W), .D_W(D_W)) u_nco (
    .clk_i, .rst_ni, .ftw_i(act.ftw), .cos_o(cos_w), .sin_o(sin_w)
  );

  qmod_mix #(.D_W(D_W)) u_mix (
    .clk_i, .rst_ni, .i_i, .q_i, .cos_i(cos_w), .sin_i(sin_w),
    .tone_i(act.tone), .inv_i(act.inv), .out_o
  );

  // R1
  rst_out_chk: assert property (@(posedge clk_i) !rst_ni |=> out_o == '0);
endmodule

// File: tb/qmod_core_bench.sv
module qmod_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  waddr = '0;
  logic [33:0] wdata = '0;
  logic [1:0]  psel = '0;
  logic signed [11:0] iv = '0, qv = '0;
  logic signed [11:0] out;

  always #2.5 clk = ~clk;

  qmod_core u_qmod_core (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .psel_i(psel), .i_i(iv), .q_i(qv), .out_o(out)
  );

  int checks = 0, fails = 0, hi_hits = 0, lo_hits = 0;
  bit done = 1'b0;
  logic [31:0] acc = '0;
  logic [31:0] m_ftw [4];
  bit          m_tone [4], m_inv [4];
  int          exp_q [3];
  string       tag_q [3];
  bit          vld_q [3];

  function automatic int ref_out(int i, int q, int p, bit tone, bit inv);
    real th;
    int  c, s, sum, r;
    th = (2.0 * p + 1.0) * 3.14159265358979 / 1024.0;
    c  = int'(2047.0 * $cos(th));
    s  = int'(2047.0 * $sin(th));
    if (tone) return c;
    sum = inv ? i * c + q * s : i * c - q * s;
    r   = (sum + 1024) >>> 11;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return r;
  endfunction

  task automatic check(string tag, int act, int expv, int tol);
    checks++;
    if (act > expv + tol || act < expv - tol) begin
      fails++;
      $display("FAIL %s: out=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(input int i, input int q, input logic [1:0] sel,
                      input bit w = 0, input logic [1:0] wa = '0, input logic [33:0] wd = '0);
    @(negedge clk);
    if (vld_q[2]) begin
      check({tag_q[2], " (R2 R6 R8 R9)"}, int'(out), exp_q[2], 2);
      if (exp_q[2] == 2047)  hi_hits++;
      if (exp_q[2] == -2048) lo_hits++;
    end
    for (int k = 2; k > 0; k--) begin
      exp_q[k] = exp_q[k-1]; tag_q[k] = tag_q[k-1]; vld_q[k] = vld_q[k-1];
    end
    iv = 12'(i); qv = 12'(q); psel = sel; we = w; waddr = wa; wdata = wd;
    exp_q[0] = ref_out(i, q, int'(acc[31:22]), m_tone[sel], m_inv[sel]);
    tag_q[0] = m_tone[sel] ? "R5" : (m_inv[sel] ? "R4" : "R3");
    vld_q[0] = 1'b1;
    acc = acc + m_ftw[sel];
    if (w) begin
      m_ftw[wa] = wd[33:2]; m_tone[wa] = wd[1]; m_inv[wa] = wd[0];
    end
  endtask

  task automatic load(input logic [1:0] wa, input logic [31:0] f, input bit t, input bit s,
                      input logic [1:0] sel);
    step($urandom_range(0, 4095) - 2048, $urandom_range(0, 4095) - 2048, sel, 1'b1, wa, {f, t, s});
  endtask

  task automatic run(input int n, input int hold, input int mode);
    logic [1:0] sel;
    int i, q;
    sel = 2'($urandom_range(0, 3));
    for (int k = 0; k < n; k++) begin
      if (k % hold == 0) sel = 2'($urandom_range(0, 3));
      case (mode)
        1: begin i = 2047;  q = -2048; end
        2: begin i = -2048; q = 2047;  end
        default: begin
          i = $urandom_range(0, 4095) - 2048;
          q = $urandom_range(0, 4095) - 2048;
        end
      endcase
      step(i, q, sel);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < 4; k++) begin m_ftw[k] = '0; m_tone[k] = 0; m_inv[k] = 0; end
    for (int k = 0; k < 3; k++) begin vld_q[k] = 0; exp_q[k] = 0; tag_q[k] = ""; end
    repeat (4) @(negedge clk);
    check("R1 reset", int'(out), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(out), 0, 0);
    // R1: cleared profiles give a still carrier at phase 0 in subtract mode
    run(20, 5, 0);
    // R9: load all four, covering both signs and tone
    load(2'd0, 32'h0123_4567, 1'b0, 1'b0, 2'd0);
    load(2'd1, 32'h0A1B_2C3D, 1'b0, 1'b1, 2'd1);
    load(2'd2, 32'h0040_0000, 1'b1, 1'b0, 2'd2);
    load(2'd3, 32'hFFFF_FFFF, 1'b0, 1'b1, 2'd3);
    run(3000, 7, 0);
    run(500, 1, 0);   // R6: switch every cycle
    for (int r = 0; r < 6; r++) begin
      for (int p = 0; p < 4; p++)
        load(2'(p), $urandom(), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 2'(p));
      run(1500, 1 + r * 3, 0);
    end
    // R7: full-scale opposite-sign inputs reach both rails
    load(2'd0, 32'h0100_0000, 1'b0, 1'b0, 2'd0);
    load(2'd1, 32'h0210_0000, 1'b0, 1'b1, 2'd1);
    load(2'd2, 32'h0300_0000, 1'b0, 1'b0, 2'd2);
    load(2'd3, 32'hFE00_0000, 1'b0, 1'b1, 2'd3);
    run(400, 11, 1);
    run(400, 11, 2);
    repeat (3) step(0, 0, 2'd0);
    checks++;
    if (hi_hits == 0 || lo_hits == 0) begin
      fails++;
      $display("FAIL R7: rail hits hi=%0d lo=%0d expected both > 0", hi_hits, lo_hits);
    end
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule